// File: doc/BRIEF.md
# Chunky to planar converter

This block turns rectangles of 4-bit pixels, held one pixel per byte, into the four bit-plane bytes that a planar frame store expects. A caller hands it a box as two corner coordinates. The block then pulls the source pixels line by line as 64-bit words of eight pixels each. For every memory byte it writes, it emits a plane-select mask, a byte address and a data byte. The source word carries pixel k in bits [8k+7:8k].

The block widens the box to whole bytes and clips it to the display. When the box lies entirely off-screen, the block drops it. For each line it first loads every source group into a local buffer, already converted to planar form. It then replays that buffer four times, once per plane. Memory arbitration belongs to the consumer of the output stream.

The controller has three states: IDLE, LOAD and EMIT.
- IDLE waits for a command. It takes "accept" to LOAD when the box is visible, and "reject" back to IDLE when it is not.
- LOAD takes source words. It moves to EMIT on "line loaded", when the last group of the line arrives.
- EMIT sends bytes. "Plane done" advances the plane. "Line done" returns to LOAD when lines remain. "Box done" returns to IDLE after plane 3 of the last line.

Top module: `c2p_converter`

## Requirements
- R1: For plane p (0..3), bit 7−k of the output byte equals bit p of source pixel k (k = 0..7), where pixel k is source bits [8k+7:8k].
- R2: Bits 7..4 of every source pixel byte have no effect on any output.
- R3: The box's left edge is rounded down to a multiple of 8 and its right edge up to the next multiple of 8 minus 1. Each line therefore covers x2/8 − x1/8 + 1 bytes before clipping.
- R4: A command whose rounded left edge is at or beyond the display width, or whose top edge is at or beyond the display height, consumes no source word and produces no output. The block is ready for a new command in the next cycle.
- R5: The right edge is clipped to display width − 1 and the bottom edge to display height − 1.
- R6: Within a line, all bytes of plane 0 leave in ascending address order, followed by plane 1, then plane 2, then plane 3. The plane mask is one-hot with bit p set for plane p.
- R7: The address of byte g on line y is y·(W/8) + x1/8 + g, where W is the display width.
- R8: While out_valid is high and out_ready is low, the plane mask, address and data hold their values, and no byte is lost or reordered.
- R9: Before a line's first output, the block consumes exactly that line's group count of source words. It consumes none during emission. cmd_ready is high only when the block is idle.
- R10: After reset, cmd_ready is 1 and src_ready and out_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Box command present |
| cmd_ready | output | 1 | Block idle, command taken on this edge |
| cmd_x1 | input | CW | Left pixel column of the box |
| cmd_y1 | input | CW | Top line of the box |
| cmd_x2 | input | CW | Right pixel column of the box |
| cmd_y2 | input | CW | Bottom line of the box |
| src_valid | input | 1 | Source word present |
| src_ready | output | 1 | Source word taken on this edge |
| src_data | input | 64 | Eight chunky pixels, pixel k in bits [8k+7:8k] |
| out_valid | output | 1 | Planar byte present |
| out_ready | input | 1 | Consumer takes the byte on this edge |
| out_plane_mask | output | 4 | One-hot plane select |
| out_addr | output | AW | Byte address in the planar store |
| out_data | output | 8 | Planar byte, pixel 0 in bit 7 |

## Verification
- **Output timing.** All handshake outputs come straight from registered state. A line's first plane-0 byte therefore appears in the cycle after the edge that accepts that line's last source word. Each following byte appears one cycle after the previous one is taken.
- **Reject timing.** After a rejected command, cmd_ready is high again in the very next cycle.
- **Sampling.** The bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. Each sample therefore shows exactly what the next rising edge will act on.
- **Bookkeeping.** The bench counts output and source handshakes as they happen. It derives the expected plane, group and line purely from those counts, so no check waits a fixed number of cycles.

// File: rtl/c2p_pkg.sv
package c2p_pkg;
    localparam int PLANES    = 4;
    localparam int GROUP_PIX = 8;
    localparam int WORD_W    = GROUP_PIX * 8;
    localparam int PLANAR_W  = PLANES * GROUP_PIX;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EMIT
    } c2p_state_e;
endpackage

// File: rtl/c2p_swizzle.sv
module c2p_swizzle
    import c2p_pkg::*;
(
    input  logic [WORD_W-1:0]   chunky,
    output logic [PLANAR_W-1:0] planar
);
    // Upper nibble of every pixel is dropped (R2).
    logic [GROUP_PIX*4-1:0] unused_hi;

    for (genvar k = 0; k < GROUP_PIX; k++) begin : g_pix
        assign unused_hi[4*k +: 4] = chunky[8*k+4 +: 4];
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            // Pixel k lands in bit 7-k of the byte for plane p (R1).
            assign planar[8*p + 7 - k] = chunky[8*k + p];
        end
    end
endmodule

// File: rtl/c2p_box_clip.sv
module c2p_box_clip #(
    parameter int DISP_W = 640,
    parameter int DISP_H = 480,
    parameter int CW     = 12,
    parameter int GW     = 8,
    parameter int LW     = 10,
    parameter int AW     = 16
) (
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    input  logic [CW-1:0] x2,
    input  logic [CW-1:0] y2,
    output logic          reject,
    output logic [GW-1:0] ngrp,
    output logic [LW-1:0] nlines,
    output logic [AW-1:0] base
);
    localparam int PITCH = DISP_W / 8;

    logic [CW-1:0] left, right_raw, right_c, bot_c, span;
    logic [5:0]    unused_lsb;

    assign unused_lsb = {x1[2:0], x2[2:0]};

    always_comb begin
        left      = {x1[CW-1:3], 3'b000};
        right_raw = {x2[CW-1:3], 3'b111};
        right_c   = (right_raw >= CW'(DISP_W)) ? CW'(DISP_W - 1) : right_raw;
        bot_c     = (y2 >= CW'(DISP_H)) ? CW'(DISP_H - 1) : y2;
        reject    = (left >= CW'(DISP_W)) || (y1 >= CW'(DISP_H));
        span      = right_c - left;
        ngrp      = GW'(span >> 3) + GW'(1);
        nlines    = LW'(bot_c - y1) + LW'(1);
        base      = AW'(y1) * AW'(PITCH) + AW'(left >> 3);
    end
endmodule

// File: rtl/c2p_line_buf.sv
module c2p_line_buf #(
    parameter int DEPTH = 80,
    parameter int DW    = 32,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH))
        else $error("line buffer write beyond depth");
endmodule

// File: rtl/c2p_converter.sv
module c2p_converter #(
    parameter  int DISP_W = 640,
    parameter  int DISP_H = 480,
    parameter  int CW     = 12,
    localparam int PITCH  = DISP_W / 8,
    localparam int IDXW   = (PITCH > 1) ? $clog2(PITCH) : 1,
    localparam int GW     = IDXW + 1,
    localparam int LW     = $clog2(DISP_H) + 1,
    localparam int AW     = $clog2(PITCH * DISP_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [CW-1:0] cmd_x1,
    input  logic [CW-1:0] cmd_y1,
    input  logic [CW-1:0] cmd_x2,
    input  logic [CW-1:0] cmd_y2,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic [63:0]   src_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [3:0]    out_plane_mask,
    output logic [AW-1:0] out_addr,
    output logic [7:0]    out_data
);
    import c2p_pkg::*;

    c2p_state_e state_q, state_d;

    logic [AW-1:0]       base_q;
    logic [GW-1:0]       ngrp_q;
    logic [LW-1:0]       lines_q;
    logic [IDXW-1:0]     grp_q;
    logic [1:0]          plane_q;

    logic                clip_reject;
    logic [GW-1:0]       clip_ngrp;
    logic [LW-1:0]       clip_lines;
    logic [AW-1:0]       clip_base;
    logic [PLANAR_W-1:0] conv_word, rd_word;

    logic last_grp, last_plane, last_line;

    assign last_grp   = ({1'b0, grp_q} == (ngrp_q - GW'(1)));
    assign last_plane = (plane_q == 2'(PLANES - 1));
    assign last_line  = (lines_q == LW'(1));

    c2p_box_clip #(
        .DISP_W(DISP_W), .DISP_H(DISP_H), .CW(CW),
        .GW(GW), .LW(LW), .AW(AW)
    ) u_clip (
        .x1(cmd_x1), .y1(cmd_y1), .x2(cmd_x2), .y2(cmd_y2),
        .reject(clip_reject), .ngrp(clip_ngrp),
        .nlines(clip_lines), .base(clip_base)
    );

    c2p_swizzle u_swz (
        .chunky(src_data),
        .planar(conv_word)
    );

    c2p_line_buf #(.DEPTH(PITCH), .DW(PLANAR_W), .IW(IDXW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .we(src_valid && src_ready), .waddr(grp_q), .wdata(conv_word),
        .raddr(grp_q), .rdata(rd_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid && !clip_reject) state_d = ST_LOAD;
            ST_LOAD: if (src_valid && last_grp) state_d = ST_EMIT;
            ST_EMIT: if (out_ready && last_grp && last_plane)
                         state_d = last_line ? ST_IDLE : ST_LOAD;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready      = (state_q == ST_IDLE);
        src_ready      = (state_q == ST_LOAD);
        out_valid      = (state_q == ST_EMIT);
        out_plane_mask = 4'b0001 << plane_q;
        out_addr       = base_q + AW'(grp_q);
        out_data       = rd_word[{plane_q, 3'b000} +: 8];
    end

    // Datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            ngrp_q  <= '0;
            lines_q <= '0;
            grp_q   <= '0;
            plane_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cmd_valid && !clip_reject) begin
                    base_q  <= clip_base;
                    ngrp_q  <= clip_ngrp;
                    lines_q <= clip_lines;
                    grp_q   <= '0;
                    plane_q <= '0;
                end
                ST_LOAD: if (src_valid) begin
                    grp_q <= last_grp ? '0 : grp_q + 1'b1;
                end
                ST_EMIT: if (out_ready) begin
                    if (last_grp) begin
                        grp_q <= '0;
                        if (last_plane) begin
                            plane_q <= '0;
                            lines_q <= lines_q - 1'b1;
                            base_q  <= base_q + AW'(PITCH);
                        end else begin
                            plane_q <= plane_q + 1'b1;
                        end
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_data) && $stable(out_plane_mask)))
        else $error("output changed under back-pressure");

    assert_single_role_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, src_ready, out_valid}))
        else $error("more than one handshake role active");

    assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_addr) < PITCH * DISP_H))
        else $error("address beyond planar store");

    assert_plane_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid
                                      || out_plane_mask == $past(out_plane_mask)
                                      || out_plane_mask == ($past(out_plane_mask) << 1)))
        else $error("plane order broken within a line");
endmodule

// File: tb/c2p_converter_test.sv
`timescale 1ns/1ps
module c2p_converter_test;
    localparam int DW_   = 640;
    localparam int DH_   = 480;
    localparam int CW    = 12;
    localparam int PITCH = DW_ / 8;
    localparam int AW    = $clog2(PITCH * DH_);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [CW-1:0] cmd_x1 = '0, cmd_y1 = '0, cmd_x2 = '0, cmd_y2 = '0;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [63:0]   src_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [3:0]    out_plane_mask;
    logic [AW-1:0] out_addr;
    logic [7:0]    out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int salt     = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    c2p_converter #(.DISP_W(DW_), .DISP_H(DH_), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_x1(cmd_x1), .cmd_y1(cmd_y1), .cmd_x2(cmd_x2), .cmd_y2(cmd_y2),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_plane_mask(out_plane_mask), .out_addr(out_addr), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pixel bytes carry a busy upper nibble so that R2 is exercised everywhere.
    function automatic logic [7:0] pix(input int x, input int y, input int s);
        return 8'((x * 29) + (y * 113) + (s * 71) + ((x >> 3) * 5));
    endfunction

    function automatic logic [7:0] plane_byte(input int x0, input int y, input int p,
                                              input int s);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = pix(x0 + k, y, s);
            b[7 - k] = v[p];
        end
        return b;
    endfunction

    function automatic logic [63:0] src_word(input int x0, input int y, input int s);
        logic [63:0] w;
        for (int k = 0; k < 8; k++) begin
            w[8*k +: 8] = pix(x0 + k, y, s);
        end
        return w;
    endfunction

    task automatic run_box(input string name, input int x1, input int y1,
                           input int x2, input int y2, input bit stall);
        int left, right, bot, ngrp, nlines, total_out, total_src;
        int out_cnt, src_cnt, cyc;
        bit rej, hold;
        logic [AW-1:0] h_addr;
        logic [7:0]    h_data;
        logic [3:0]    h_mask;
        salt++;
        left  = x1 & ~7;
        right = (x2 & ~7) + 7;
        rej   = (left >= DW_) || (y1 >= DH_);
        if (right >= DW_) right = DW_ - 1;
        bot   = (y2 >= DH_) ? DH_ - 1 : y2;
        ngrp   = rej ? 0 : (right - left + 1) / 8;
        nlines = rej ? 0 : bot - y1 + 1;
        total_out = ngrp * nlines * 4;
        total_src = ngrp * nlines;
        out_cnt = 0; src_cnt = 0; cyc = 0; hold = 1'b0;
        h_addr = '0; h_data = '0; h_mask = '0;

        @(negedge clk);
        cmd_x1 = CW'(x1); cmd_y1 = CW'(y1); cmd_x2 = CW'(x2); cmd_y2 = CW'(y2);
        cmd_valid = 1'b1; src_valid = 1'b0; out_ready = 1'b0;
        #1;
        chk(cmd_ready, "R9", {name, " ready while idle"}, cmd_ready, 1);

        while ((out_cnt < total_out || src_cnt < total_src) && cyc < 20000) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            src_valid = (stall && ($urandom % 4 == 0)) ? 1'b0 : 1'b1;
            if (src_cnt < total_src)
                src_data = src_word(left + 8 * (src_cnt % ngrp), y1 + src_cnt / ngrp, salt);
            else
                src_data = '0;
            out_ready = stall ? 1'($urandom % 2) : 1'b1;
            #1;
            if (hold) begin
                chk(out_valid && out_addr == h_addr && out_data == h_data
                    && out_plane_mask == h_mask, "R8", {name, " held byte"},
                    out_addr, h_addr);
                hold = 1'b0;
            end
            if (out_valid) begin
                int line, rem, p, g;
                line = out_cnt / (ngrp * 4);
                rem  = out_cnt % (ngrp * 4);
                p    = rem / ngrp;
                g    = rem % ngrp;
                if (out_cnt >= total_out) begin
                    chk(1'b0, "R6", {name, " extra output byte"}, out_cnt, total_out);
                end else begin
                    chk(out_data == plane_byte(left + 8 * g, y1 + line, p, salt),
                        "R1 R2", {name, " planar data"}, out_data,
                        plane_byte(left + 8 * g, y1 + line, p, salt));
                    chk(int'(out_addr) == (y1 + line) * PITCH + left / 8 + g,
                        "R7 R3 R5", {name, " address"}, out_addr,
                        (y1 + line) * PITCH + left / 8 + g);
                    chk(out_plane_mask == 4'(1 << p), "R6", {name, " plane mask"},
                        out_plane_mask, 1 << p);
                    chk(src_cnt == (line + 1) * ngrp, "R9", {name, " line loaded first"},
                        src_cnt, (line + 1) * ngrp);
                end
                if (out_ready) begin
                    out_cnt++;
                end else begin
                    hold = 1'b1;
                    h_addr = out_addr; h_data = out_data; h_mask = out_plane_mask;
                end
            end
            if (src_valid && src_ready) begin
                if (src_cnt >= total_src)
                    chk(1'b0, "R9", {name, " extra source word"}, src_cnt, total_src);
                src_cnt++;
            end
            cyc++;
        end
        if (cyc >= 20000)
            chk(1'b0, "R6", {name, " box never finished"}, out_cnt, total_out);

        if (rej) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                cmd_valid = 1'b0; src_valid = 1'b1; out_ready = 1'b1;
                #1;
                chk(!src_ready && !out_valid, "R4", {name, " rejected box idle"},
                    {src_ready, out_valid}, 0);
                chk(cmd_ready, "R4", {name, " ready after reject"}, cmd_ready, 1);
            end
        end

        @(negedge clk);
        cmd_valid = 1'b0; src_valid = 1'b0; out_ready = 1'b1;
        #1;
        chk(cmd_ready && !out_valid && !src_ready, "R9", {name, " back to idle"},
            {cmd_ready, src_ready, out_valid}, 4);
        chk(src_cnt == total_src, "R9 R3", {name, " source words used"}, src_cnt, total_src);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(cmd_ready == 1'b1, "R10", "reset cmd_ready", cmd_ready, 1);
        chk(src_ready == 1'b0, "R10", "reset src_ready", src_ready, 0);
        chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    endtask

    task automatic t_aligned();      run_box("aligned R1", 16, 2, 31, 3, 1'b0);     endtask
    task automatic t_unaligned();    run_box("unaligned R3", 13, 5, 42, 5, 1'b0);   endtask
    task automatic t_single_byte();  run_box("one byte R3", 100, 7, 101, 9, 1'b0);  endtask
    task automatic t_clip();         run_box("clip R5", 620, 470, 700, 500, 1'b0);  endtask
    task automatic t_reject_left();  run_box("reject left R4", 643, 0, 700, 3, 1'b0); endtask
    task automatic t_reject_top();   run_box("reject top R4", 0, 480, 10, 490, 1'b0); endtask
    task automatic t_backpressure(); run_box("stall R8", 40, 10, 95, 12, 1'b1);     endtask

    task automatic t_random();
        for (int i = 0; i < 10; i++) begin
            int x1, y1;
            x1 = $urandom % 700;
            y1 = $urandom % 500;
            run_box("random", x1, y1, x1 + ($urandom % 64), y1 + ($urandom % 5),
                    1'($urandom % 2));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aligned();
        t_unaligned();
        t_single_byte();
        t_clip();
        t_reject_left();
        t_reject_top();
        t_backpressure();
        t_random();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule